// File: doc/BRIEF.md
# Data watchpoint byte-range matcher

This block decides whether one data access touches any byte watched by a single watchpoint. The access is described by its start address and its length in bytes (1 to 16). Two flags say how much of the address is meaningful: a 32-bit regime flag and a tag-ignore flag that drops the top address byte. The watchpoint is programmed with a 64-bit value, an 8-bit byte-select field and a 5-bit address-mask exponent. The single output says whether a watched byte was touched.

Matching is combinational. Sixteen byte lanes each test one address of the access against the programmed value, and a configuration decoder shared by all lanes works out which bits take part in the compare. Every case left open to the implementation is resolved in a fixed way. A reserved mask value disables the watchpoint. Nonzero value bits inside the masked range suppress the match. A nonzero mask combined with a partial byte-select field makes the whole masked region watched. A non-contiguous byte-select field is used bit by bit, exactly as written. By default the result is registered, which adds one cycle of latency. Privilege checks, load/store filtering and exception generation are left to neighbouring logic.

Top module: `wp_range_match`

## Requirements
- R1: While rst_n is low, hit_o is 0. With the default output register, hit_o shows the match result of the inputs present at the previous rising clock edge.
- R2: When wv_value bit 2 is 0 and addr_mask is 0, a byte at address A matches only if A and wv_value agree on bits [top:3] and byte_sel bit A[2:0] is 1.
- R3: When wv_value bit 2 is 1 and addr_mask is 0, a byte matches only if A and wv_value agree on bits [top:2] and byte_sel bit A[1:0] is 1. byte_sel bits [7:4] and wv_value bits [1:0] have no effect.
- R4: An access matches if any byte from acc_addr to acc_addr+acc_size-1 matches. An acc_size of 0 never matches, and sizes above 16 act as 16.
- R5: With addr_mask M in 3..31 greater than the granule base bit and byte_sel = 8'hFF, only address bits [top:M] are compared.
- R6: An addr_mask of 1 or 2 gives no match for any access.
- R7: With addr_mask M greater than the granule base bit b, any 1 in wv_value bits [M-1:b] gives no match.
- R8: With a nonzero, non-reserved addr_mask and byte_sel other than 8'hFF, byte_sel is ignored and every byte that passes the address compare matches.
- R9: A non-contiguous byte_sel (for example 8'h05) is applied bit by bit: only bytes whose select bit is 1 match.
- R10: When regime32 is 1, top is 31. Otherwise, when tag_ignore is 1, top is 55. Otherwise top is 63. Address and value bits above top have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the surrounding logic |
| acc_addr | input | 64 | Start address of the access |
| acc_size | input | 5 | Number of bytes accessed |
| regime32 | input | 1 | 1: compare address bits [31:0] only |
| tag_ignore | input | 1 | 1: ignore address bits [63:56] (no effect when regime32 is 1) |
| wv_value | input | 64 | Programmed watch address; bit 2 selects word granularity |
| byte_sel | input | 8 | Byte-select field within the word or doubleword |
| addr_mask | input | 5 | Number of low address bits masked (0 = none; 1 and 2 reserved) |
| hit_o | output | 1 | A watched byte is touched by the access |

## Verification
Suppose the decoder picks the wrong low compare bit or the wrong top bit. Then hit_o flips for addresses just across a granule, masked-region or tag boundary, so the directed vectors are placed on both sides of each such edge. Suppose instead that a lane is enabled wrongly or its address offset is wrong. That shows up only on accesses whose first or last byte straddles a watched byte, so accesses of sizes 0, 4, 5, 15, 16 and over 16 sit right at a watched byte. Every error appears on hit_o exactly one clock after the inputs are applied, and the scoreboard compares it on that cycle.

// File: rtl/wp_match_pkg.sv
package wp_match_pkg;
  localparam int ADDR_W    = 64;
  localparam int SEL_W     = 8;
  localparam int MASK_W    = 5;
  localparam int MAX_BYTES = 16;
  localparam int SIZE_W    = $clog2(MAX_BYTES + 1);
  localparam int NARROW_W  = 32;
  localparam int TAG_W     = 8;
  localparam int IDX_W     = $clog2(SEL_W);

  // Shared decode result handed from the configuration decoder to every lane
  typedef struct packed {
    logic [ADDR_W-1:0] cmp_mask;   // address bits that take part in the compare
    logic              word_gran;  // 1: word granule, 0: doubleword granule
    logic              sel_bypass; // 1: byte select ignored
    logic              kill;       // reserved mask or suppressed configuration
  } wp_cfg_t;
endpackage

// File: rtl/wp_cfg_decode.sv
module wp_cfg_decode
  import wp_match_pkg::*;
(
  input  logic [ADDR_W-1:0] wv_value,
  input  logic [SEL_W-1:0]  byte_sel,
  input  logic [MASK_W-1:0] addr_mask,
  input  logic              regime32,
  input  logic              tag_ignore,
  output wp_cfg_t           cfg
);
  int unsigned top_bit;
  int unsigned base_bit;
  int unsigned low_bit;
  int unsigned mask_val;
  logic        reserved;
  logic        masked_dirty;
  logic        masking;

  always_comb begin
    mask_val = int'(addr_mask);
    base_bit = wv_value[2] ? 2 : 3;
    if (regime32)        top_bit = NARROW_W - 1;
    else if (tag_ignore) top_bit = ADDR_W - TAG_W - 1;
    else                 top_bit = ADDR_W - 1;
    reserved = (mask_val == 1) || (mask_val == 2);
    masking  = mask_val > base_bit;
    low_bit  = masking ? mask_val : base_bit;
    masked_dirty = 1'b0;
    for (int b = 0; b < ADDR_W; b++) begin
      cfg.cmp_mask[b] = (b >= low_bit) && (b <= top_bit);
      if (masking && (b >= base_bit) && (b < mask_val) && wv_value[b])
        masked_dirty = 1'b1;
    end
    cfg.word_gran  = wv_value[2];
    cfg.sel_bypass = (addr_mask != '0) && (byte_sel != {SEL_W{1'b1}});
    cfg.kill       = reserved || masked_dirty;
  end
endmodule

// File: rtl/wp_byte_lane.sv
module wp_byte_lane
  import wp_match_pkg::*;
(
  input  logic [ADDR_W-1:0] lane_addr,
  input  logic [ADDR_W-1:0] wv_value,
  input  logic [SEL_W-1:0]  byte_sel,
  input  wp_cfg_t           cfg,
  input  logic              lane_en,
  output logic              lane_hit
);
  logic [IDX_W-1:0] sel_idx;
  logic             addr_eq;
  logic             sel_ok;

  always_comb begin
    sel_idx = lane_addr[IDX_W-1:0];
    if (cfg.word_gran) sel_idx[IDX_W-1] = 1'b0;
    addr_eq  = ((lane_addr ^ wv_value) & cfg.cmp_mask) == '0;
    sel_ok   = cfg.sel_bypass || byte_sel[sel_idx];
    lane_hit = lane_en && addr_eq && sel_ok;
  end
endmodule

// File: rtl/wp_range_match.sv
module wp_range_match
  import wp_match_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic              regime32,
  input  logic              tag_ignore,
  input  logic [ADDR_W-1:0] wv_value,
  input  logic [SEL_W-1:0]  byte_sel,
  input  logic [MASK_W-1:0] addr_mask,
  output logic              hit_o
);
  wp_cfg_t                cfg;
  logic [MAX_BYTES-1:0]   lane_hits;
  logic                   hit_comb;

  wp_cfg_decode u_decode (
    .wv_value   (wv_value),
    .byte_sel   (byte_sel),
    .addr_mask  (addr_mask),
    .regime32   (regime32),
    .tag_ignore (tag_ignore),
    .cfg        (cfg)
  );

  for (genvar k = 0; k < MAX_BYTES; k++) begin : g_lane
    logic [ADDR_W-1:0] this_addr;
    logic              this_en;
    assign this_addr = acc_addr + ADDR_W'(k);
    assign this_en   = SIZE_W'(k) < acc_size;
    wp_byte_lane u_lane (
      .lane_addr (this_addr),
      .wv_value  (wv_value),
      .byte_sel  (byte_sel),
      .cfg       (cfg),
      .lane_en   (this_en),
      .lane_hit  (lane_hits[k])
    );
  end

  assign hit_comb = (|lane_hits) && !cfg.kill;

  if (OUT_REG) begin : g_oreg
    logic hit_q;
    logic hit_d;
    logic hit_en;

    always_comb begin
      hit_en = 1'b1;
      hit_d  = hit_q;
      if (hit_en) hit_d = hit_comb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit_q <= 1'b0;
      else        hit_q <= hit_d;
    end

    assign hit_o = hit_q;

    // R1
    reg_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (hit_o == $past(hit_comb)));
  end else begin : g_comb
    assign hit_o = hit_comb;
  end

  // R6
  reserved_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr_mask == 5'd1) || (addr_mask == 5'd2)) |-> !hit_comb);

  // R4
  zero_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_size == '0) |-> !hit_comb);

  // R7
  dirty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr_mask == 5'd4) && !wv_value[2] && wv_value[3]) |-> !hit_comb);

  // R2
  empty_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr_mask == '0) && (byte_sel == '0)) |-> !hit_comb);
endmodule

// File: tb/wp_range_match_tb.sv
module wp_range_match_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] acc_addr;
  logic [4:0]  acc_size;
  logic        regime32;
  logic        tag_ignore;
  logic [63:0] wv_value;
  logic [7:0]  byte_sel;
  logic [4:0]  addr_mask;
  logic        hit_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit exp_q[$];
  string tag_q[$];
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #2 clk = ~clk;

  wp_range_match dut_i (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_size(acc_size),
    .regime32(regime32), .tag_ignore(tag_ignore), .wv_value(wv_value),
    .byte_sel(byte_sel), .addr_mask(addr_mask), .hit_o(hit_o)
  );

  function automatic bit model(input logic [63:0] a0, input int sz, input bit r32,
                               input bit ti, input logic [63:0] v,
                               input logic [7:0] bs, input int m);
    int top, base, lo, n;
    logic [63:0] a;
    bit eq, sel;
    top  = r32 ? 31 : (ti ? 55 : 63);
    base = v[2] ? 2 : 3;
    if (m == 1 || m == 2) return 1'b0;
    lo = (m > base) ? m : base;
    if (m > base)
      for (int b = base; b < m; b++) if (v[b]) return 1'b0;
    n = (sz > 16) ? 16 : sz;
    for (int k = 0; k < n; k++) begin
      a  = a0 + 64'(k);
      eq = 1'b1;
      for (int b = lo; b <= top; b++) if (a[b] != v[b]) eq = 1'b0;
      if (m != 0 && bs != 8'hFF) sel = 1'b1;
      else if (base == 2)        sel = bs[a[1:0]];
      else                       sel = bs[a[2:0]];
      if (eq && sel) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic apply(input logic [63:0] a, input int sz, input bit r32, input bit ti,
                       input logic [63:0] v, input logic [7:0] bs, input int m,
                       input string tag);
    @(negedge clk);
    acc_addr = a; acc_size = 5'(sz); regime32 = r32; tag_ignore = ti;
    wv_value = v; byte_sel = bs; addr_mask = 5'(m);
    exp_q.push_back(model(a, sz, r32, ti, v, bs, m));
    tag_q.push_back(tag);
  endtask

  function automatic logic [63:0] nxt();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    return rng;
  endfunction

  // monitor: result appears one register after the driving negedge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_checks++;
        if (hit_o !== e) begin
          n_fail++;
          $display("FAIL %s: hit_o=%0b expected=%0b", t, hit_o, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    acc_addr = 64'h1000; acc_size = 5'd1; regime32 = 1'b0; tag_ignore = 1'b0;
    wv_value = 64'h1000; byte_sel = 8'h01; addr_mask = 5'd0;
    repeat (3) @(negedge clk);
    n_checks++;
    if (hit_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: hit_o=%0b expected=0", hit_o);
    end
    rst_n = 1'b1;

    // R2 doubleword granule
    apply(64'h1000, 1, 0, 0, 64'h1000, 8'h01, 0, "R2");
    apply(64'h1001, 1, 0, 0, 64'h1000, 8'h01, 0, "R2");
    apply(64'h1007, 1, 0, 0, 64'h1000, 8'h80, 0, "R2");
    apply(64'h1008, 1, 0, 0, 64'h1000, 8'h80, 0, "R2");
    apply(64'h1000, 8, 0, 0, 64'h1000, 8'h00, 0, "R2");
    // R3 word granule, upper select bits and low value bits ignored
    apply(64'h1004, 4, 0, 0, 64'h1004, 8'hF0, 0, "R3");
    apply(64'h1005, 1, 0, 0, 64'h1004, 8'h02, 0, "R3");
    apply(64'h1005, 1, 0, 0, 64'h1007, 8'h02, 0, "R3");
    apply(64'h1001, 1, 0, 0, 64'h1004, 8'h02, 0, "R3");
    // R4 access range
    apply(64'h1FFC, 4, 0, 0, 64'h2000, 8'h01, 0, "R4");
    apply(64'h1FFC, 5, 0, 0, 64'h2000, 8'h01, 0, "R4");
    apply(64'h2000, 0, 0, 0, 64'h2000, 8'h01, 0, "R4");
    apply(64'h1FF1, 15, 0, 0, 64'h2000, 8'h01, 0, "R4");
    apply(64'h1FF1, 16, 0, 0, 64'h2000, 8'h01, 0, "R4");
    apply(64'h1FF1, 31, 0, 0, 64'h2000, 8'h01, 0, "R4");
    // R5 masking
    apply(64'h40FF, 1, 0, 0, 64'h4000, 8'hFF, 8, "R5");
    apply(64'h4100, 1, 0, 0, 64'h4000, 8'hFF, 8, "R5");
    apply(64'h3FFF, 2, 0, 0, 64'h4000, 8'hFF, 8, "R5");
    // R6 reserved mask
    apply(64'h4000, 1, 0, 0, 64'h4000, 8'hFF, 1, "R6");
    apply(64'h4000, 1, 0, 0, 64'h4000, 8'hFF, 2, "R6");
    // R7 dirty masked value bits
    apply(64'h4010, 1, 0, 0, 64'h4010, 8'hFF, 8, "R7");
    apply(64'h4008, 1, 0, 0, 64'h4008, 8'hFF, 4, "R7");
    // R8 partial select under mask
    apply(64'h40F7, 1, 0, 0, 64'h4000, 8'h01, 8, "R8");
    apply(64'h1003, 1, 0, 0, 64'h1000, 8'h01, 3, "R8");
    // R9 non-contiguous select
    apply(64'h1001, 1, 0, 0, 64'h1000, 8'h05, 0, "R9");
    apply(64'h1002, 1, 0, 0, 64'h1000, 8'h05, 0, "R9");
    // R10 top bit selection
    apply(64'hFFFF_FFFF_0000_1000, 1, 1, 0, 64'h1000, 8'h01, 0, "R10");
    apply(64'hFFFF_FFFF_0000_1000, 1, 0, 0, 64'h1000, 8'h01, 0, "R10");
    apply(64'hAB00_0000_0000_1000, 1, 0, 1, 64'h1000, 8'h01, 0, "R10");
    apply(64'hAB00_0000_0000_1000, 1, 0, 0, 64'h1000, 8'h01, 0, "R10");
    apply(64'h0080_0000_0000_1000, 1, 0, 1, 64'h1000, 8'h01, 0, "R10");

    // mixed patterns near the watched address
    for (int i = 0; i < 300; i++) begin
      logic [63:0] v, a, r;
      int m, sz;
      r  = nxt();
      v  = {r[63:56] & {8{r[5]}}, 40'h0, r[23:0]};
      r  = nxt();
      a  = v + 64'(r[5:0]) - 64'd32;
      if (r[6]) a[63:56] = r[63:56];
      sz = int'(r[11:7]) % 18;
      m  = r[12] ? 0 : int'(r[17:13]) % 12;
      r  = nxt();
      apply(a, sz, r[0], r[1], v, r[1] ? r[15:8] : 8'hFF, m, "R4");
    end

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule